// File: doc/BRIEF.md
# FIFO-Style Command/Response Status Sequencer

This block is the handshake logic that sits behind a byte-wide, FIFO-style register window of a trusted security module. A host reaches it through a plain register bus: a 3-bit address, a write strobe, a read strobe and byte-wide data in each direction. The host reads a status byte and an extended status byte. It puts the block into its ready phase and streams command bytes into one data port. It starts execution and then drains the response through the same data port. A 16-bit burst count tells the host how many data-port accesses it may make before it must poll status again.

Command processing itself is not part of the block. An external engine sees `exec_req`, reads the command from the shared byte buffer and writes its response back into that buffer. It then pulses `eng_done` together with the response length. The host may abort a running command with a cancel bit. In that case the block produces a fixed cancelled response itself and tells the engine to stop. A retry bit replays the held response from its first byte.

Register addresses: 0 status, 1 burst count low byte, 2 burst count high byte, 3 extended status, 4 data port. Any other address reads 0x00.

Top module: `fsq_status_seq`

## Requirements
- R1: After reset the status byte reads 0x80 (bit 7 valid set, no other flag), with bit 2 following the `selftest_ok` input. The burst count reads 0 and a data-port read returns 0xFF.
- R2: Writing a status byte with bit 6 (ready) set while idle or while a response is held enters the receive phase with an empty buffer. Status then reads 0xC8 (valid, ready, expect) and the burst count equals the buffer depth.
- R3: The command length is the big-endian 32-bit value held in command bytes 2 to 5. Status bit 3 (expect) stays 1 until at least six bytes and at least that many bytes have arrived. While expect is 1 the burst count equals depth minus bytes received. Bit 6 reads 1 only while no byte has arrived.
- R4: A data-port write is dropped when expect is 0 or the buffer is full. A dropped byte changes neither the burst count nor the buffer contents.
- R5: Writing status bit 5 (go) while expect is 1 is ignored. With expect 0 in the receive phase it raises `exec_req`. During execution the status byte reads 0x00 apart from bit 2.
- R6: An `eng_done` pulse during execution enters the response phase. Status then reads 0x90 (valid, data available) and the burst count equals the remaining response bytes. Data-port reads return the response bytes in order. Once all bytes are read, bit 4 clears and the data port returns 0xFF.
- R7: Writing status bit 1 (retry) while a response is held makes the next data-port read return the first response byte again, and restores the burst count to the full length.
- R8: Writing extended-status bit 0 (cancel) during execution ends execution and pulses `exec_abort` high for the one cycle after the write. It also presents the 10-byte cancelled response 80 01 00 00 00 0A 00 00 09 08.
- R9: A cancel written in the receive phase or while a response is held has no effect on status, burst count or response data.
- R10: The extended status byte reads the family code in bits 3:2 (default 01) and 0 in all other bits.
- R11: Ready writes during execution are ignored, and so are `eng_done` pulses outside execution.
- R12: A response length reported above the buffer depth is clamped to the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops the data port) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from address |
| selftest_ok | input | 1 | Self-test complete flag shown in status bit 2 |
| exec_req | output | 1 | High while the engine owns the command |
| exec_abort | output | 1 | One-cycle pulse after a cancel during execution |
| eng_raddr | input | AW | Engine buffer read address |
| eng_rdata | output | 8 | Engine buffer read data |
| eng_we | input | 1 | Engine buffer write enable (honoured during execution) |
| eng_waddr | input | AW | Engine buffer write address |
| eng_wdata | input | 8 | Engine buffer write data |
| eng_done | input | 1 | Engine completion pulse |
| eng_rsp_len | input | 16 | Response length in bytes, sampled with eng_done |

## Verification
A wrong byte counter shows up at once in the burst count, because every accepted byte lowers it by one. The expect bit then clears one byte early or late, which blocks or admits go at the wrong moment. A wrong read pointer or response length shows on the very next data-port read: the byte is out of sequence, data-available drops early, or a 0xFF appears inside the response. A stray phase change caused by an ignored cancel, ready or done shows on the next status read as a changed flag pattern. A missing abort pulse shows on `exec_abort` in the cycle right after the cancel write.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RX   = 2'd1,
    PH_EXEC = 2'd2,
    PH_RESP = 2'd3
  } fsq_phase_e;

  localparam logic [2:0] REG_STS  = 3'd0;
  localparam logic [2:0] REG_BCL  = 3'd1;
  localparam logic [2:0] REG_BCH  = 3'd2;
  localparam logic [2:0] REG_STX  = 3'd3;
  localparam logic [2:0] REG_DATA = 3'd4;

  localparam int STS_VALID  = 7;
  localparam int STS_READY  = 6;
  localparam int STS_GO     = 5;
  localparam int STS_AVAIL  = 4;
  localparam int STS_EXPECT = 3;
  localparam int STS_STDONE = 2;
  localparam int STS_RETRY  = 1;
  localparam int STX_CANCEL = 0;

  localparam int HDR_BYTES = 6;
  localparam int CXL_BYTES = 10;

  function automatic logic [7:0] cxl_byte(input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'h80;
      4'd1:    b = 8'h01;
      4'd5:    b = 8'h0A;
      4'd8:    b = 8'h09;
      4'd9:    b = 8'h08;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/fsq_buf.sv
module fsq_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata_a = mem[raddr_a];
    rdata_b = mem[raddr_b];
  end

endmodule

// File: rtl/fsq_lenparse.sv
module fsq_lenparse #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          byte_we,
  input  logic [CW-1:0] cnt,
  input  logic [7:0]    byte_val,
  output logic          expect_o
);

  import fsq_pkg::*;

  logic [31:0] len_q, len_d;
  logic [31:0] cnt32;

  always_comb begin
    cnt32 = 32'(cnt);
    len_d = len_q;
    if (clr) begin
      len_d = '0;
    end else if (byte_we) begin
      case (cnt32)
        32'd2:   len_d[31:24] = byte_val;
        32'd3:   len_d[23:16] = byte_val;
        32'd4:   len_d[15:8]  = byte_val;
        32'd5:   len_d[7:0]   = byte_val;
        default: len_d = len_q;
      endcase
    end
    expect_o = (cnt32 < 32'(HDR_BYTES)) || (cnt32 < len_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (clr || byte_we) begin
      len_q <= len_d;
    end
  end

endmodule

// File: rtl/fsq_ctrl.sv
module fsq_ctrl #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_ready,
  input  logic                 cmd_go,
  input  logic                 cmd_retry,
  input  logic                 cmd_cancel,
  input  logic                 data_wr,
  input  logic                 data_rd,
  input  logic                 expect_i,
  input  logic                 eng_done,
  input  logic [15:0]          eng_len,
  output fsq_pkg::fsq_phase_e  phase_o,
  output logic [CW-1:0]        wr_cnt_o,
  output logic [CW-1:0]        rd_ptr_o,
  output logic [CW-1:0]        rsp_len_o,
  output logic                 cancelled_o,
  output logic                 abort_o,
  output logic                 clr_o,
  output logic                 accept_o
);

  import fsq_pkg::*;

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] CXL_C   = CW'(CXL_BYTES);
  localparam logic [31:0]   DEPTH32 = DEPTH;

  fsq_phase_e    phase_q, phase_d;
  logic [CW-1:0] wr_cnt_q, wr_cnt_d;
  logic [CW-1:0] rd_q, rd_d;
  logic [CW-1:0] rlen_q, rlen_d;
  logic          cxl_q, cxl_d;
  logic          abort_q, abort_d;
  logic [CW-1:0] eng_len_clamped;
  logic          accept;

  always_comb begin
    if (32'(eng_len) > DEPTH32) begin
      eng_len_clamped = DEPTH_C;
    end else begin
      eng_len_clamped = CW'(eng_len);
    end
    accept = (phase_q == PH_RX) && data_wr && expect_i && (wr_cnt_q < DEPTH_C);
  end

  always_comb begin
    phase_d  = phase_q;
    wr_cnt_d = wr_cnt_q;
    rd_d     = rd_q;
    rlen_d   = rlen_q;
    cxl_d    = cxl_q;
    abort_d  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (cmd_ready) begin
          phase_d  = PH_RX;
          wr_cnt_d = '0;
        end
      end
      PH_RX: begin
        if (cmd_ready) begin
          wr_cnt_d = '0;
        end else if (cmd_go && !expect_i) begin
          phase_d = PH_EXEC;
        end else if (accept) begin
          wr_cnt_d = wr_cnt_q + CW'(1);
        end
      end
      PH_EXEC: begin
        if (cmd_cancel) begin
          phase_d = PH_RESP;
          cxl_d   = 1'b1;
          rlen_d  = CXL_C;
          rd_d    = '0;
          abort_d = 1'b1;
        end else if (eng_done) begin
          phase_d = PH_RESP;
          cxl_d   = 1'b0;
          rlen_d  = eng_len_clamped;
          rd_d    = '0;
        end
      end
      PH_RESP: begin
        if (cmd_ready) begin
          phase_d  = PH_RX;
          wr_cnt_d = '0;
          rd_d     = '0;
          rlen_d   = '0;
          cxl_d    = 1'b0;
        end else if (cmd_retry) begin
          rd_d = '0;
        end else if (data_rd && (rd_q < rlen_q)) begin
          rd_d = rd_q + CW'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      wr_cnt_q <= '0;
      rd_q     <= '0;
      rlen_q   <= '0;
      cxl_q    <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      wr_cnt_q <= wr_cnt_d;
      rd_q     <= rd_d;
      rlen_q   <= rlen_d;
      cxl_q    <= cxl_d;
      abort_q  <= abort_d;
    end
  end

  always_comb begin
    phase_o     = phase_q;
    wr_cnt_o    = wr_cnt_q;
    rd_ptr_o    = rd_q;
    rsp_len_o   = rlen_q;
    cancelled_o = cxl_q;
    abort_o     = abort_q;
    clr_o       = cmd_ready && (phase_q != PH_EXEC);
    accept_o    = accept;
  end

  assert_hdr_before_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RX && !expect_i) |-> (wr_cnt_q >= CW'(HDR_BYTES)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_q <= DEPTH_C);

  assert_go_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RX && cmd_go && expect_i && !cmd_ready) |=> (phase_q == PH_RX));

  assert_rd_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q <= rlen_q);

  assert_retry_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RESP && cmd_retry && !cmd_ready) |=> (rd_q == '0));

  assert_cancel_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RESP && cmd_cancel && !cmd_ready)
      |=> (phase_q == PH_RESP && $stable(cxl_q) && $stable(rlen_q)));

  assert_exec_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC && !cmd_cancel && !eng_done) |=> (phase_q == PH_EXEC));

  assert_clamp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rlen_q <= DEPTH_C);

endmodule

// File: rtl/fsq_status_seq.sv
module fsq_status_seq #(
  parameter int         DEPTH  = 16,
  parameter logic [1:0] FAMILY = 2'b01,
  parameter int         AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          selftest_ok,
  output logic          exec_req,
  output logic          exec_abort,
  input  logic [AW-1:0] eng_raddr,
  output logic [7:0]    eng_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  logic [7:0]    eng_wdata,
  input  logic          eng_done,
  input  logic [15:0]   eng_rsp_len
);

  import fsq_pkg::*;

  localparam int            CW      = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          cmd_ready, cmd_go, cmd_retry, cmd_cancel;
  logic          data_wr, data_rd;
  logic          expect_w, clr_w, accept_w, cancelled_w, abort_w;
  fsq_phase_e    phase_w;
  logic [CW-1:0] wr_cnt_w, rd_ptr_w, rsp_len_w;
  logic          buf_we;
  logic [AW-1:0] buf_waddr;
  logic [7:0]    buf_wdata, buf_rsp;
  logic          avail, expect_bit;
  logic [7:0]    sts_byte, stx_byte;
  logic [CW-1:0] burst_small;
  logic [15:0]   burst;

  always_comb begin
    cmd_ready  = host_wr && (host_addr == REG_STS) && host_wdata[STS_READY];
    cmd_go     = host_wr && (host_addr == REG_STS) && host_wdata[STS_GO];
    cmd_retry  = host_wr && (host_addr == REG_STS) && host_wdata[STS_RETRY];
    cmd_cancel = host_wr && (host_addr == REG_STX) && host_wdata[STX_CANCEL];
    data_wr    = host_wr && (host_addr == REG_DATA);
    data_rd    = host_rd && (host_addr == REG_DATA);
  end

  fsq_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .cmd_go     (cmd_go),
    .cmd_retry  (cmd_retry),
    .cmd_cancel (cmd_cancel),
    .data_wr    (data_wr),
    .data_rd    (data_rd),
    .expect_i   (expect_w),
    .eng_done   (eng_done),
    .eng_len    (eng_rsp_len),
    .phase_o    (phase_w),
    .wr_cnt_o   (wr_cnt_w),
    .rd_ptr_o   (rd_ptr_w),
    .rsp_len_o  (rsp_len_w),
    .cancelled_o(cancelled_w),
    .abort_o    (abort_w),
    .clr_o      (clr_w),
    .accept_o   (accept_w)
  );

  fsq_lenparse #(.CW(CW)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_w),
    .byte_we  (accept_w),
    .cnt      (wr_cnt_w),
    .byte_val (host_wdata),
    .expect_o (expect_w)
  );

  always_comb begin
    exec_req  = (phase_w == PH_EXEC);
    buf_we    = accept_w || (eng_we && exec_req);
    buf_waddr = accept_w ? AW'(wr_cnt_w) : eng_waddr;
    buf_wdata = accept_w ? host_wdata : eng_wdata;
  end

  fsq_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk     (clk),
    .we      (buf_we),
    .waddr   (buf_waddr),
    .wdata   (buf_wdata),
    .raddr_a (eng_raddr),
    .rdata_a (eng_rdata),
    .raddr_b (AW'(rd_ptr_w)),
    .rdata_b (buf_rsp)
  );

  always_comb begin
    avail      = (phase_w == PH_RESP) && (rd_ptr_w < rsp_len_w);
    expect_bit = (phase_w == PH_RX) && expect_w;

    sts_byte             = 8'h00;
    sts_byte[STS_VALID]  = (phase_w != PH_EXEC);
    sts_byte[STS_READY]  = (phase_w == PH_RX) && (wr_cnt_w == '0);
    sts_byte[STS_AVAIL]  = avail;
    sts_byte[STS_EXPECT] = expect_bit;
    sts_byte[STS_STDONE] = selftest_ok;

    stx_byte      = 8'h00;
    stx_byte[3:2] = FAMILY;

    if (expect_bit) begin
      burst_small = DEPTH_C - wr_cnt_w;
    end else if (phase_w == PH_RESP) begin
      burst_small = rsp_len_w - rd_ptr_w;
    end else begin
      burst_small = '0;
    end
    burst = 16'(burst_small);

    case (host_addr)
      REG_STS:  host_rdata = sts_byte;
      REG_BCL:  host_rdata = burst[7:0];
      REG_BCH:  host_rdata = burst[15:8];
      REG_STX:  host_rdata = stx_byte;
      REG_DATA: begin
        if (!avail) begin
          host_rdata = 8'hFF;
        end else if (cancelled_w) begin
          host_rdata = cxl_byte(4'(rd_ptr_w));
        end else begin
          host_rdata = buf_rsp;
        end
      end
      default:  host_rdata = 8'h00;
    endcase

    exec_abort = abort_w;
  end

  assert_abort_to_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_abort |-> (phase_w == PH_RESP && cancelled_w));

endmodule

// File: tb/fsq_status_seq_test.sv
module fsq_status_seq_test;

  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    h_addr;
  logic          h_wr, h_rd;
  logic [7:0]    h_wdata, h_rdata;
  logic          st_ok;
  logic          exec_req, exec_abort;
  logic [AW-1:0] e_raddr, e_waddr;
  logic [7:0]    e_rdata, e_wdata;
  logic          e_we, e_done;
  logic [15:0]   e_len;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fsq_status_seq #(.DEPTH(DEPTH), .FAMILY(2'b01), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .host_addr(h_addr), .host_wr(h_wr), .host_rd(h_rd),
    .host_wdata(h_wdata), .host_rdata(h_rdata), .selftest_ok(st_ok),
    .exec_req(exec_req), .exec_abort(exec_abort), .eng_raddr(e_raddr), .eng_rdata(e_rdata),
    .eng_we(e_we), .eng_waddr(e_waddr), .eng_wdata(e_wdata), .eng_done(e_done),
    .eng_rsp_len(e_len)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic popit, output logic [7:0] d);
    @(negedge clk); h_addr = a; h_rd = popit; #1 d = h_rdata;
    @(negedge clk); h_rd = 1'b0;
  endtask

  function automatic logic [7:0] cmd_byte(input int i, input int len, input int n);
    case (i)
      0: return 8'h80;
      1: return 8'h01;
      2: return 8'(len >> 24);
      3: return 8'(len >> 16);
      4: return 8'(len >> 8);
      5: return 8'(len);
      default: return 8'((i * 13 + n) & 255);
    endcase
  endfunction

  function automatic logic [7:0] rsp_byte(input int i, input int rl);
    return 8'((i * 29 + rl * 3 + 5) & 255);
  endfunction

  function automatic logic [7:0] cxl_exp(input int i);
    case (i)
      0: return 8'h80; 1: return 8'h01; 5: return 8'h0A; 8: return 8'h09; 9: return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  task automatic eng_fill_and_done(input int rl);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); e_we = 1'b1; e_waddr = AW'(i); e_wdata = rsp_byte(i, rl);
    end
    @(negedge clk); e_we = 1'b0; e_done = 1'b1; e_len = 16'(rl);
    @(negedge clk); e_done = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int prev_rl;
    int mism;
    rst_n = 1'b0; h_addr = '0; h_wr = 0; h_rd = 0; h_wdata = '0; st_ok = 0;
    e_raddr = '0; e_waddr = '0; e_wdata = '0; e_we = 0; e_done = 0; e_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, 0, v); check("R1 status", v, 8'h80);
    rd(3'd1, 0, v); check("R1 burst", v, 8'h00);
    rd(3'd4, 1, v); check("R1 data", v, 8'hFF);
    st_ok = 1'b1;
    rd(3'd0, 0, v); check("R1 selftest bit", v, 8'h84);
    st_ok = 1'b0;
    // R10 extended status
    rd(3'd3, 0, v); check("R10 family", v, 8'h04);
    // R11 done outside execution ignored
    @(negedge clk); e_done = 1; e_len = 16'd5; @(negedge clk); e_done = 0;
    rd(3'd0, 0, v); check("R11 done in idle", v, 8'h80);

    // R2 ready from idle
    wr(3'd0, 8'h40);
    rd(3'd0, 0, v); check("R2 status", v, 8'hC8);
    rd(3'd1, 0, v); check("R2 burst", v, 8'(DEPTH));
    rd(3'd2, 0, v); check("R2 burst high", v, 8'h00);

    // Sweep command lengths
    prev_rl = -1;
    for (int n = 6; n <= DEPTH; n++) begin
      int rl, eff;
      rl  = n * 3 - 14;
      eff = (rl > DEPTH) ? DEPTH : rl;
      wr(3'd0, 8'h40);
      for (int k = 0; k < n; k++) begin
        if (k == n - 1) begin
          wr(3'd0, 8'h20);
          check("R5 go blocked while expect", {31'd0, exec_req}, 32'd0);
        end
        wr(3'd4, cmd_byte(k, n, n));
        rd(3'd0, 0, v);
        check("R3 expect", {31'd0, v[3]}, {31'd0, (k + 1 < n)});
        check("R3 ready bit", {31'd0, v[6]}, 32'd0);
        rd(3'd1, 0, v);
        check("R3 burst", v, (k + 1 < n) ? 8'(DEPTH - k - 1) : 8'd0);
      end
      // R4 extra byte dropped
      wr(3'd4, 8'h55);
      rd(3'd1, 0, v); check("R4 burst after drop", v, 8'h00);
      // R9 cancel in receive ignored
      wr(3'd3, 8'h01);
      rd(3'd0, 0, v); check("R9 cancel in rx", v, 8'h80);
      // R5 go
      wr(3'd0, 8'h20);
      check("R5 exec_req", {31'd0, exec_req}, 32'd1);
      rd(3'd0, 0, v); check("R5 status in exec", v, 8'h00);
      // R11 ready during exec ignored
      wr(3'd0, 8'h40);
      check("R11 ready in exec", {31'd0, exec_req}, 32'd1);
      mism = 0;
      for (int i = 0; i < n; i++) begin
        @(negedge clk); e_raddr = AW'(i); #1;
        if (e_rdata !== cmd_byte(i, n, n)) mism++;
      end
      check("R3 command bytes stored", mism, 0);
      if (prev_rl >= 0 && n < DEPTH) begin
        @(negedge clk); e_raddr = AW'(n); #1;
        check("R4 dropped byte not stored", e_rdata, rsp_byte(n, prev_rl));
      end
      eng_fill_and_done(rl);
      prev_rl = rl;
      rd(3'd0, 0, v); check("R6 status resp", v, 8'h90);
      rd(3'd1, 0, v); check("R12 burst clamp", v, 8'(eff));
      for (int i = 0; i < 2; i++) begin
        rd(3'd4, 1, v); check("R6 byte", v, rsp_byte(i, rl));
      end
      wr(3'd0, 8'h02);
      rd(3'd1, 0, v); check("R7 burst after retry", v, 8'(eff));
      wr(3'd3, 8'h01);
      rd(3'd0, 0, v); check("R9 cancel in resp", v, 8'h90);
      for (int i = 0; i < eff; i++) begin
        rd(3'd4, 1, v); check("R7 replayed byte", v, rsp_byte(i, rl));
      end
      rd(3'd0, 0, v); check("R6 drained status", v, 8'h80);
      rd(3'd4, 1, v); check("R6 drained data", v, 8'hFF);
    end

    // R8 cancel during execution
    wr(3'd0, 8'h40);
    for (int k = 0; k < 10; k++) wr(3'd4, cmd_byte(k, 10, 10));
    wr(3'd0, 8'h20);
    check("R8 exec started", {31'd0, exec_req}, 32'd1);
    wr(3'd3, 8'h01);
    check("R8 abort pulse", {31'd0, exec_abort}, 32'd1);
    check("R8 exec ended", {31'd0, exec_req}, 32'd0);
    @(negedge clk);
    check("R8 abort one cycle", {31'd0, exec_abort}, 32'd0);
    @(negedge clk); e_done = 1; e_len = 16'd3; @(negedge clk); e_done = 0;
    rd(3'd0, 0, v); check("R8 status", v, 8'h90);
    rd(3'd1, 0, v); check("R8 burst", v, 8'd10);
    for (int i = 0; i < 10; i++) begin
      rd(3'd4, 1, v); check("R8 cancel response", v, cxl_exp(i));
    end
    rd(3'd0, 0, v); check("R8 drained", v, 8'h80);

    // R4 buffer full with oversized length
    wr(3'd0, 8'h40);
    for (int k = 0; k < DEPTH; k++) wr(3'd4, cmd_byte(k, 20, 3));
    rd(3'd0, 0, v); check("R4 full still expects", v, 8'h88);
    rd(3'd1, 0, v); check("R4 full burst", v, 8'h00);
    wr(3'd4, 8'hAA);
    wr(3'd0, 8'h20);
    check("R5 go blocked when full", {31'd0, exec_req}, 32'd0);
    // R2 ready restarts from receive phase
    wr(3'd0, 8'h40);
    rd(3'd0, 0, v); check("R2 restart", v, 8'hC8);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule